// File: doc/BRIEF.md
# Shift, Rotate and Scaled-Add Unit

A purely combinational execution-stage unit that extends a plain barrel shifter with four families of bit manipulation: rotates in both directions, shifts that bring in ones instead of zeros, a butterfly network that can either permute bits (generalized reverse) or OR each bit with its permuted partners (OR-combine), and address-style adds that scale the first operand by 1, 2, 4 or 8 before adding the second.

The caller presents the first operand, a second operand that holds either a register value or a shift immediate, a 4-bit operation code and a word-mode flag. The result appears on the output in the same cycle. On a 64-bit datapath the word flag selects 32-bit forms: rotates, ones-shifts and butterfly operations work on the low 32 bits and sign-extend, while the scaled adds zero-extend the low 32 bits of the first operand first. On a 32-bit build the word flag has no effect. Instruction decode and register file access belong to the surrounding pipeline.

Top module: `shift_unit`

## Requirements
- R1: With opCode 0 (rotate right) or 1 (rotate left) and word mode clear, the result is srcA rotated by srcB[5:0] bit positions; higher bits of srcB are ignored.
- R2: With opCode 0 or 1 and word mode set, only srcA[31:0] is rotated, by srcB[4:0], within 32 bits, and the 32-bit result is sign-extended from its bit 31 to 64 bits.
- R3: opCode 2 shifts srcA left and opCode 3 shifts it right by srcB[5:0], filling vacated positions with ones; with word mode set the same is done on srcA[31:0] by srcB[4:0] and the result is sign-extended from bit 31.
- R4: opCode 4 (generalized reverse) gives result bit i equal to source bit (i XOR c), where c is srcB[5:0] (or srcB[4:0] on the low 32 bits, sign-extended, in word mode); c = 56 reverses the byte order of the 64-bit value.
- R5: opCode 5 (OR-combine) gives result bit i equal to the OR of every source bit j for which (i XOR j) has ones only where c has ones; c and word mode are taken as in R4.
- R6: opCodes 6, 7, 8 and 9 give (srcA shifted left by 0, 1, 2 or 3) plus srcB, modulo 2^64; with word mode set, srcA is first replaced by its low 32 bits zero-extended (opCode 6 with word mode is the zero-extending add).
- R7: opCode 10 gives srcA[31:0] zero-extended and then shifted left by srcB[5:0], truncated to 64 bits.
- R8: opCodes 11 to 15 give a result of zero.
- R9: The word-mode flag has no effect on opCode 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 4 | Operation select, encoding as given in the requirements |
| wordMode | input | 1 | Selects 32-bit forms (ignored on a 32-bit build) |
| srcA | input | 64 | First operand (value to shift, rotate, permute or scale) |
| srcB | input | 64 | Second operand: amount, butterfly control or addend |
| result | output | 64 | Operation result |

## Verification
The embedded checks evaluate in the same combinational pass that forms the result, so they take for granted that every input is a known value and holds steady while the output settles; an input changing in the middle of a check would be outside their scope. The bench respects this by driving all four inputs together just after one clock edge and reading the result at the opposite edge. Random stimulus covers the full 4-bit code space, including the unassigned codes, with both word-mode settings and full 64-bit operands so that the ignored high bits of the amount are exercised; directed cases add the byte-reversal control, zero and maximum amounts, and operands whose upper halves must be discarded.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [3:0] {
    OP_ROR    = 4'd0,
    OP_ROL    = 4'd1,
    OP_SLO    = 4'd2,
    OP_SRO    = 4'd3,
    OP_GREV   = 4'd4,
    OP_GORC   = 4'd5,
    OP_SH0ADD = 4'd6,
    OP_SH1ADD = 4'd7,
    OP_SH2ADD = 4'd8,
    OP_SH3ADD = 4'd9,
    OP_SLLIUW = 4'd10
  } opCode_e;

  typedef struct packed {
    logic       doRotate;
    logic       rotLeft;
    logic       doOnes;
    logic       onesLeft;
    logic       doFly;
    logic       flyOr;
    logic       doAdd;
    logic [1:0] addShift;
    logic       doSlli;
    logic       zextA;
    logic       wordOp;
  } strobes_t;

endpackage

// File: rtl/shift_unit_fly.sv
module shift_unit_fly #(
  parameter int W = 64
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] ctrl,
  input  logic                 orMode,
  output logic [W-1:0]         dout
);
  localparam int STAGES = $clog2(W);

  logic [W-1:0] stg [STAGES+1];
  logic [W-1:0] swp [STAGES];

  assign stg[0] = din;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int PARTNER = i ^ (1 << k);
      assign swp[k][i] = stg[k][PARTNER];
    end
    assign stg[k+1] = !ctrl[k] ? stg[k] :
                      (orMode ? (stg[k] | swp[k]) : swp[k]);
  end

  assign dout = stg[STAGES];
endmodule

// File: rtl/shift_unit_ctrl.sv
module shift_unit_ctrl
  import shift_unit_pkg::*;
#(
  parameter bit HAS_WORD = 1'b1
) (
  input  logic [3:0] opCode,
  input  logic       wordMode,
  output strobes_t   strobes
);
  logic wordEff;
  assign wordEff = wordMode & HAS_WORD;

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_ROR:    begin strobes.doRotate = 1'b1; strobes.wordOp = wordEff; end
      OP_ROL:    begin strobes.doRotate = 1'b1; strobes.rotLeft = 1'b1; strobes.wordOp = wordEff; end
      OP_SLO:    begin strobes.doOnes = 1'b1; strobes.onesLeft = 1'b1; strobes.wordOp = wordEff; end
      OP_SRO:    begin strobes.doOnes = 1'b1; strobes.wordOp = wordEff; end
      OP_GREV:   begin strobes.doFly = 1'b1; strobes.wordOp = wordEff; end
      OP_GORC:   begin strobes.doFly = 1'b1; strobes.flyOr = 1'b1; strobes.wordOp = wordEff; end
      OP_SH0ADD: begin strobes.doAdd = 1'b1; strobes.addShift = 2'd0; strobes.zextA = wordEff; end
      OP_SH1ADD: begin strobes.doAdd = 1'b1; strobes.addShift = 2'd1; strobes.zextA = wordEff; end
      OP_SH2ADD: begin strobes.doAdd = 1'b1; strobes.addShift = 2'd2; strobes.zextA = wordEff; end
      OP_SH3ADD: begin strobes.doAdd = 1'b1; strobes.addShift = 2'd3; strobes.zextA = wordEff; end
      OP_SLLIUW: begin strobes.doSlli = 1'b1; strobes.zextA = 1'b1; end
      default:   strobes = '0;
    endcase
  end

  always_comb begin
    // R8
    strobe_onehot_chk: assert ($onehot0({strobes.doRotate, strobes.doOnes, strobes.doFly,
                                         strobes.doAdd, strobes.doSlli}));
  end
endmodule

// File: rtl/shift_unit_dp.sv
module shift_unit_dp
  import shift_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  strobes_t          st,
  input  logic [XLEN-1:0]   srcA,
  input  logic [XLEN-1:0]   srcB,
  output logic [XLEN-1:0]   result
);
  localparam int LOGW = $clog2(XLEN);
  localparam bit HAS_WORD = (XLEN == 64);
  localparam logic [XLEN-1:0] LOW32 = XLEN'(64'h0000_0000_FFFF_FFFF);

  logic [LOGW-1:0]   amtFull;
  logic [LOGW-1:0]   amtNeg;
  logic [2*XLEN-1:0] rotWideR;
  logic [2*XLEN-1:0] rotWideL;
  logic [XLEN-1:0]   rotRes;
  logic [XLEN-1:0]   onesRes;
  logic [XLEN-1:0]   flyRes;
  logic [XLEN-1:0]   addRes;
  logic [XLEN-1:0]   slliRes;
  logic [XLEN-1:0]   aExt;
  logic [XLEN-1:0]   wordRes;

  assign amtFull  = srcB[LOGW-1:0];
  assign amtNeg   = -amtFull;
  assign rotWideR = {srcA, srcA} >> amtFull;
  assign rotWideL = {srcA, srcA} >> amtNeg;
  assign rotRes   = st.rotLeft ? rotWideL[XLEN-1:0] : rotWideR[XLEN-1:0];
  assign onesRes  = st.onesLeft ? ~((~srcA) << amtFull) : ~((~srcA) >> amtFull);

  shift_unit_fly #(.W(XLEN)) i_flyFull (
    .din(srcA), .ctrl(amtFull), .orMode(st.flyOr), .dout(flyRes)
  );

  assign aExt    = st.zextA ? (srcA & LOW32) : srcA;
  assign addRes  = (aExt << st.addShift) + srcB;
  assign slliRes = (srcA & LOW32) << amtFull;

  if (HAS_WORD) begin : g_word
    logic [4:0]  amtW;
    logic [4:0]  amtWNeg;
    logic [31:0] a32;
    logic [63:0] rot32R;
    logic [63:0] rot32L;
    logic [31:0] rot32;
    logic [31:0] ones32;
    logic [31:0] fly32;
    logic [31:0] sel32;

    assign amtW    = srcB[4:0];
    assign amtWNeg = -amtW;
    assign a32     = srcA[31:0];
    assign rot32R  = {a32, a32} >> amtW;
    assign rot32L  = {a32, a32} >> amtWNeg;
    assign rot32   = st.rotLeft ? rot32L[31:0] : rot32R[31:0];
    assign ones32  = st.onesLeft ? ~((~a32) << amtW) : ~((~a32) >> amtW);

    shift_unit_fly #(.W(32)) i_flyWord (
      .din(a32), .ctrl(amtW), .orMode(st.flyOr), .dout(fly32)
    );

    always_comb begin
      if (st.doRotate)    sel32 = rot32;
      else if (st.doOnes) sel32 = ones32;
      else                sel32 = fly32;
    end
    assign wordRes = {{(XLEN-32){sel32[31]}}, sel32};
  end else begin : g_noWord
    assign wordRes = '0;
  end

  always_comb begin
    result = '0;
    if (st.wordOp && (st.doRotate || st.doOnes || st.doFly)) result = wordRes;
    else if (st.doRotate) result = rotRes;
    else if (st.doOnes)   result = onesRes;
    else if (st.doFly)    result = flyRes;
    else if (st.doAdd)    result = addRes;
    else if (st.doSlli)   result = slliRes;
  end

  always_comb begin
    // R1
    rot_pop_chk: assert (!(st.doRotate && !st.wordOp) || ($countones(result) == $countones(srcA)));
    // R5
    gorc_cover_chk: assert (!(st.doFly && st.flyOr && !st.wordOp) || ((result & srcA) == srcA));
    // R3
    slo_fill_chk: assert (!(st.doOnes && st.onesLeft && !st.wordOp) ||
                          ((((~result) >> amtFull) << amtFull) == ~result));
    // R7
    slli_low_chk: assert (!st.doSlli || (((result >> amtFull) << amtFull) == result));
    // R2
    word_sext_chk: assert (!(st.wordOp && (st.doRotate || st.doOnes || st.doFly)) ||
                           (&result[XLEN-1:31]) || !(|result[XLEN-1:31]));
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      opCode,
  input  logic            wordMode,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result
);
  strobes_t strobes;

  shift_unit_ctrl #(.HAS_WORD(XLEN == 64)) i_ctrl (
    .opCode(opCode), .wordMode(wordMode), .strobes(strobes)
  );

  shift_unit_dp #(.XLEN(XLEN)) i_dp (
    .st(strobes), .srcA(srcA), .srcB(srcB), .result(result)
  );

  always_comb begin
    // R8
    unused_code_zero_chk: assert ((opCode <= 4'd10) || (result == '0));
  end
endmodule

// File: tb/test_shift_unit.sv
module test_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = '0;
  logic        wordMode = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit i_shift_unit (
    .opCode(opCode), .wordMode(wordMode), .srcA(srcA), .srcB(srcB), .result(result)
  );

  function automatic logic [63:0] bitOp(input int op, input int n, input logic [63:0] a,
                                        input int amt);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) begin
      case (op)
        0: r[i] = a[(i + amt) % n];
        1: r[i] = a[(i - amt + n) % n];
        2: r[i] = (i < amt) ? 1'b1 : a[i - amt];
        3: r[i] = (i + amt >= n) ? 1'b1 : a[i + amt];
        4: r[i] = a[i ^ amt];
        default: begin
          r[i] = 1'b0;
          for (int j = 0; j < n; j++)
            if ((((i ^ j) & ~amt) & (n - 1)) == 0) r[i] = r[i] | a[j];
        end
      endcase
    end
    return r;
  endfunction

  function automatic logic [63:0] refModel(input logic [3:0] op, input logic w,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [63:0] ax;
    if (op <= 4'd5) begin
      if (w) begin
        r = bitOp(int'(op), 32, {32'd0, a[31:0]}, int'(b[4:0]));
        r = {{32{r[31]}}, r[31:0]};
      end else begin
        r = bitOp(int'(op), 64, a, int'(b[5:0]));
      end
    end else if (op <= 4'd9) begin
      ax = w ? {32'd0, a[31:0]} : a;
      r = ax;
      for (int k = 6; k < int'(op); k++) r = r * 64'd2;
      r = r + b;
    end else if (op == 4'd10) begin
      r = {32'd0, a[31:0]};
      for (int k = 0; k < int'(b[5:0]); k++) r = {r[62:0], 1'b0};
    end else begin
      r = '0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h (op=%0d w=%0d a=%h b=%h)",
               tag, got, exp, opCode, wordMode, srcA, srcB);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic w, input logic [63:0] a,
                       input logic [63:0] b);
    @(posedge clk);
    opCode = op; wordMode = w; srcA = a; srcB = b;
    @(negedge clk);
  endtask

  function automatic string tagOf(input logic [3:0] op, input logic w);
    if (op <= 4'd1) return w ? "R2" : "R1";
    if (op <= 4'd3) return "R3";
    if (op == 4'd4) return "R4";
    if (op == 4'd5) return "R5";
    if (op <= 4'd9) return "R6";
    if (op == 4'd10) return "R7";
    return "R8";
  endfunction

  task automatic runCase(input logic [3:0] op, input logic w, input logic [63:0] a,
                         input logic [63:0] b);
    apply(op, w, a, b);
    check(tagOf(op, w), result, refModel(op, w, a, b));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] keep;
    int unsigned seed;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: all-zero inputs select a rotate of zero
    check("R1", result, 64'd0);

    // R4 byte reversal with control 56
    apply(4'd4, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd56);
    check("R4", result, 64'hEFCD_AB89_6745_2301);
    // R1 amount zero and high amount bits ignored
    runCase(4'd0, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'd0);
    runCase(4'd1, 1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FF3F);
    apply(4'd0, 1'b0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0041);
    check("R1", result, 64'h8000_0000_0000_0001);
    // R2 word rotate discards upper value bits, sign-extends
    apply(4'd0, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'h25);
    check("R2", result, 64'h0000_0000_0800_0000);
    apply(4'd1, 1'b1, 64'h0000_0000_4000_0000, 64'd1);
    check("R2", result, 64'hFFFF_FFFF_8000_0000);
    // R3 ones fill, extreme amounts
    apply(4'd2, 1'b0, 64'd0, 64'd63);
    check("R3", result, 64'h7FFF_FFFF_FFFF_FFFF);
    apply(4'd3, 1'b1, 64'd0, 64'd4);
    check("R3", result, 64'hFFFF_FFFF_F000_0000);
    // R5 OR-combine within bytes
    apply(4'd5, 1'b0, 64'h0000_0000_0001_0080, 64'd7);
    check("R5", result, 64'h0000_0000_00FF_00FF);
    // R6 scaled add, zero-extended forms
    apply(4'd9, 1'b1, 64'hFFFF_FFFF_0000_0010, 64'd5);
    check("R6", result, 64'h0000_0000_0000_0085);
    apply(4'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    check("R6", result, 64'h0000_0001_0000_0000);
    runCase(4'd8, 1'b0, 64'hC000_0000_0000_0001, 64'd3);
    // R7 shift of zero-extended word
    apply(4'd10, 1'b0, 64'hABCD_0000_8000_0001, 64'd33);
    check("R7", result, 64'h0000_0002_0000_0000);
    keep = result;
    // R9 word flag ignored on opCode 10
    apply(4'd10, 1'b1, 64'hABCD_0000_8000_0001, 64'd33);
    check("R9", result, keep);
    // R8 unassigned codes
    apply(4'd11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8", result, 64'd0);
    apply(4'd15, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'd7);
    check("R8", result, 64'd0);

    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  op = 4'($urandom);
      logic        w  = 1'($urandom);
      logic [63:0] a  = {$urandom, $urandom};
      logic [63:0] b  = {$urandom, $urandom};
      if (n % 5 == 0) a = {32'hFFFF_FFFF, a[31:0]};
      runCase(op, w, a, b);
      if (op == 4'd10) begin
        keep = result;
        apply(op, ~w, a, b);
        check("R9", result, keep);
      end
    end
    summary();
  end
endmodule